// File: doc/BRIEF.md
# Power-Loss Recovery Wake Controller

This block follows the platform sleep state across a complete loss of main and standby power. When standby power comes back, it picks the state to resume in. The choice depends on a programmable stay-off policy bit and on the sleep state that was recorded when the failure struck. Sleep state S4 is handled apart from the lighter sleep states and from the on state.

The block keeps three groups of bits, each cleared by a different source:

- **Wake-status flags** sit in the standby well. They are held clear while the standby-good level is low.
- **Power-failure flags** record a low main power-good and a low standby-good. Only the cold reset of the always-on RTC well clears them, apart from software clearing.
- **Enable bits and the recorded sleep state** survive any main or standby outage. Only the cold RTC-well reset clears them.

After an outage, three sources can pull the system out of a sleep state: the power button, ring indicate and the RTC alarm. The power button cannot be masked. Ring indicate and the RTC alarm each have their own enable. The PME event is recorded in a status flag but never causes a wake.

Software reaches the block through a simple write port. It can record the sleep state being entered, program the enable bits and clear status flags. The block drives a one-cycle wake request and shows the resulting state and the flags on its outputs.

Top module: `plr_wake_ctrl`

## Requirements
- R1: State codes on `next_state` are S0=0, S1=1, S3=3, S4=4, S5=5. The recovery edge is the first clock edge that samples `stby_ok` high after it was low. On that edge, with stay-off bit (enable bit 0) at 1, a recorded S0, S1, S3 or S5 becomes S5.
- R2: With the stay-off bit at 1, a recorded S4 is still S4 after the recovery edge.
- R3: With the stay-off bit at 0, the state after the recovery edge is S0, whatever state was recorded.
- R4: A wake is due when all of these hold: the state is not S0, `stby_ok` is high and it is not the recovery edge. A wake source is any of: button status (flag bit 0); ring status (flag bit 1) with ring enable (enable bit 2); alarm status (flag bit 2) with alarm enable (enable bit 1). On the edge after such a flag is set, `wake_req` is high for exactly one cycle and the state becomes S0. No other flag can cause a wake.
- R5: The button can always wake and has no enable. A high-to-low change of `pwr_btn_n` sets flag bit 0 on the edge that samples it low.
- R6: While `stby_ok` is low, the button, ring, alarm and PME flags (bits 0 to 3) are forced to 0, even if their events are active.
- R7: If `ring_n` is low when standby power returns, ring status is set on the recovery edge. It then wakes the system on the next edge if ring enable is set. If ring enable is clear, ring status is set but no wake follows.
- R8: A low `main_pok` sets flag bit 5. A low `stby_ok` sets flag bit 4. The two flags are set independently of each other.
- R9: Enable bits are bit 0 stay-off, bit 1 alarm enable, bit 2 ring enable and bit 3 PME enable. They are written at address 1 and keep their value through main and standby outages. Only a low `rtc_rst_n` clears them. A low `rtc_rst_n` also clears every flag and sets the state to S5.
- R10: The PME event sets flag bit 3. With PME enable set, the PME flag never produces `wake_req` and leaves the state unchanged.
- R11: Writing address 2 clears each flag whose data bit is 1. If a set condition is present in the same cycle, the set wins.
- R12: Writing address 0 records the sleep state from data bits [2:0]. Only codes 0, 1, 3, 4 and 5 are accepted. Writes with any other code, and writes made while `stby_ok` is low, leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rtc_rst_n | input | 1 | Cold reset of the always-on RTC well, active low |
| stby_ok | input | 1 | Standby well good; low means standby power is lost |
| main_pok | input | 1 | Main power good; low means main power is lost |
| pwr_btn_n | input | 1 | Power button, active low |
| ring_n | input | 1 | Ring indicate, active low |
| rtc_alarm | input | 1 | RTC alarm event, active high |
| pme_evt | input | 1 | Power-management event, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 sleep state, 1 enables, 2 status clear |
| wr_data | input | 6 | Register write data |
| next_state | output | 3 | Current or next sleep state code |
| wake_req | output | 1 | One-cycle wake request |
| status_flags | output | 6 | Flags: bit 0 button, bit 1 ring, bit 2 alarm, bit 3 PME, bit 4 standby loss, bit 5 main loss |
| enable_bits | output | 4 | Enable bits as described in R9 |

## Verification
Each status flag changes on the first edge that samples its input event. `wake_req` and the move to S0 come one edge after that flag. The recovered state appears on the first edge that samples `stby_ok` high, so ring-indicate wakes after a return land two edges after `stby_ok` rises. The driver pushes each expected value only after stepping past the exact edge that should produce it. The monitor compares at the following falling clock edge, so every comparison reads values settled from one known edge.

// File: rtl/plr_pkg.sv
package plr_pkg;

    // Register file geometry
    localparam int REG_W     = 6;
    localparam int ADDR_W    = 2;
    localparam int NUM_FLAGS = 6;
    localparam int NUM_EN    = 4;
    localparam int SLP_W     = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_SLEEP  = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    // Flag positions
    localparam int FL_BTN   = 0;
    localparam int FL_RING  = 1;
    localparam int FL_ALARM = 2;
    localparam int FL_PME   = 3;
    localparam int FL_STBY  = 4;
    localparam int FL_MAIN  = 5;

    // Flags held clear while standby power is absent
    localparam logic [NUM_FLAGS-1:0] STBY_WELL_MASK = 6'b00_1111;

    // Enable positions
    localparam int EN_STAYOFF = 0;
    localparam int EN_ALARM   = 1;
    localparam int EN_RING    = 2;
    localparam int EN_PME     = 3;

    typedef enum logic [SLP_W-1:0] {
        SLP_S0 = 3'd0,
        SLP_S1 = 3'd1,
        SLP_S3 = 3'd3,
        SLP_S4 = 3'd4,
        SLP_S5 = 3'd5
    } slp_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } wr_req_t;

    function automatic logic is_valid_slp(logic [SLP_W-1:0] code);
        case (code)
            3'd0, 3'd1, 3'd3, 3'd4, 3'd5: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    // State to resume in once standby power returns
    function automatic slp_e recover_slp(slp_e at_fail, logic stay_off);
        if (!stay_off)
            return SLP_S0;
        else if (at_fail == SLP_S4)
            return SLP_S4;
        else
            return SLP_S5;
    endfunction

endpackage

// File: rtl/plr_flag_bank.sv
module plr_flag_bank
    import plr_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         cold_clr,
    input  logic [N-1:0] force_clr,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (cold_clr)
                q[i] <= 1'b0;
            else if (force_clr[i])
                q[i] <= 1'b0;
            else if (set_ev[i])
                q[i] <= 1'b1;
            else if (w1c[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/plr_en_reg.sv
module plr_en_reg
    import plr_pkg::*;
#(
    parameter int N = NUM_EN
) (
    input  logic         clk,
    input  logic         cold_clr,
    input  logic         we,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (cold_clr)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R9
    en_kept_chk: assert property (@(posedge clk) disable iff (cold_clr)
        !we |=> $stable(q));
endmodule

// File: rtl/plr_state_seq.sv
module plr_state_seq
    import plr_pkg::*;
(
    input  logic             clk,
    input  logic             cold_clr,
    input  logic             stby_ok,
    input  logic             stay_off,
    input  logic             wake_any,
    input  logic             slp_we,
    input  logic [SLP_W-1:0] slp_wd,
    output logic [SLP_W-1:0] slp_out,
    output logic             wake_req
);
    slp_e slp;
    logic stby_q;
    logic recov;

    assign recov   = stby_ok && !stby_q;
    assign slp_out = slp;

    always_ff @(posedge clk) begin
        if (cold_clr) begin
            slp      <= SLP_S5;
            stby_q   <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            stby_q   <= stby_ok;
            wake_req <= 1'b0;
            if (recov) begin
                slp <= recover_slp(slp, stay_off);
            end else if (stby_ok && slp != SLP_S0 && wake_any) begin
                slp      <= SLP_S0;
                wake_req <= 1'b1;
            end else if (stby_ok && slp_we && is_valid_slp(slp_wd)) begin
                slp <= slp_e'(slp_wd);
            end
        end
    end

    // R1
    off_to_s5_chk: assert property (@(posedge clk) disable iff (cold_clr)
        (recov && stay_off && slp != SLP_S4) |=> slp == SLP_S5);
    // R2
    s4_kept_chk: assert property (@(posedge clk) disable iff (cold_clr)
        (recov && stay_off && slp == SLP_S4) |=> slp == SLP_S4);
    // R3
    boot_on_chk: assert property (@(posedge clk) disable iff (cold_clr)
        (recov && !stay_off) |=> slp == SLP_S0);
    // R4
    wake_pulse_chk: assert property (@(posedge clk) disable iff (cold_clr)
        wake_req |=> !wake_req);
    // R12
    frozen_chk: assert property (@(posedge clk) disable iff (cold_clr)
        (!stby_ok && !$past(stby_ok)) |-> $stable(slp));
endmodule

// File: rtl/plr_wake_ctrl.sv
module plr_wake_ctrl
    import plr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rtc_rst_n,
    input  logic                 stby_ok,
    input  logic                 main_pok,
    input  logic                 pwr_btn_n,
    input  logic                 ring_n,
    input  logic                 rtc_alarm,
    input  logic                 pme_evt,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [SLP_W-1:0]     next_state,
    output logic                 wake_req,
    output logic [NUM_FLAGS-1:0] status_flags,
    output logic [NUM_EN-1:0]    enable_bits
);
    logic                 cold_clr;
    wr_req_t              wr;
    logic                 btn_q;
    logic [NUM_FLAGS-1:0] set_ev;
    logic [NUM_FLAGS-1:0] force_clr;
    logic [NUM_FLAGS-1:0] w1c;
    logic                 wake_any;

    assign cold_clr = !rtc_rst_n;
    assign wr       = '{en: wr_en, addr: wr_addr, data: wr_data};

    // Button level history for edge detection
    always_ff @(posedge clk) begin
        if (cold_clr)
            btn_q <= 1'b1;
        else
            btn_q <= pwr_btn_n;
    end

    always_comb begin
        set_ev           = '0;
        set_ev[FL_BTN]   = stby_ok && btn_q && !pwr_btn_n;
        set_ev[FL_RING]  = stby_ok && !ring_n;
        set_ev[FL_ALARM] = stby_ok && rtc_alarm;
        set_ev[FL_PME]   = stby_ok && pme_evt;
        set_ev[FL_STBY]  = !stby_ok;
        set_ev[FL_MAIN]  = !main_pok;
    end

    assign force_clr = {NUM_FLAGS{!stby_ok}} & STBY_WELL_MASK;
    assign w1c       = (wr.en && wr.addr == A_STATUS) ? wr.data[NUM_FLAGS-1:0] : '0;

    plr_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .cold_clr (cold_clr),
        .force_clr(force_clr),
        .set_ev   (set_ev),
        .w1c      (w1c),
        .q        (status_flags)
    );

    plr_en_reg #(.N(NUM_EN)) u_en (
        .clk     (clk),
        .cold_clr(cold_clr),
        .we      (wr.en && wr.addr == A_ENABLE),
        .d       (wr.data[NUM_EN-1:0]),
        .q       (enable_bits)
    );

    assign wake_any = status_flags[FL_BTN]
                    || (status_flags[FL_RING]  && enable_bits[EN_RING])
                    || (status_flags[FL_ALARM] && enable_bits[EN_ALARM]);

    plr_state_seq u_seq (
        .clk     (clk),
        .cold_clr(cold_clr),
        .stby_ok (stby_ok),
        .stay_off(enable_bits[EN_STAYOFF]),
        .wake_any(wake_any),
        .slp_we  (wr.en && wr.addr == A_SLEEP),
        .slp_wd  (wr.data[SLP_W-1:0]),
        .slp_out (next_state),
        .wake_req(wake_req)
    );

    // R6
    stby_clear_chk: assert property (@(posedge clk) disable iff (cold_clr)
        !stby_ok |=> (status_flags[3:0] == 4'b0000));
    // R8
    main_loss_chk: assert property (@(posedge clk) disable iff (cold_clr)
        !main_pok |=> status_flags[FL_MAIN]);
    // R8
    stby_loss_chk: assert property (@(posedge clk) disable iff (cold_clr)
        !stby_ok |=> status_flags[FL_STBY]);
    // R10
    pme_no_wake_chk: assert property (@(posedge clk) disable iff (cold_clr)
        wake_req |-> $past(status_flags[FL_BTN]
                          || (status_flags[FL_RING]  && enable_bits[EN_RING])
                          || (status_flags[FL_ALARM] && enable_bits[EN_ALARM])));
    // R4
    wake_to_on_chk: assert property (@(posedge clk) disable iff (cold_clr)
        wake_req |-> (next_state == 3'd0) && $past(stby_ok));
endmodule

// File: tb/tb_plr_wake_ctrl.sv
module tb_plr_wake_ctrl;
    logic       clk = 1'b0;
    logic       rtc_rst_n, stby_ok, main_pok, pwr_btn_n, ring_n, rtc_alarm, pme_evt;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [5:0] wr_data;
    logic [2:0] next_state;
    logic       wake_req;
    logic [5:0] status_flags;
    logic [3:0] enable_bits;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam int F_STATE = 0, F_WAKE = 1, F_FLAGS = 2, F_EN = 3;

    typedef struct {
        string req;
        int    fld;
        int    exp;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    plr_wake_ctrl dut (
        .clk(clk), .rtc_rst_n(rtc_rst_n), .stby_ok(stby_ok), .main_pok(main_pok),
        .pwr_btn_n(pwr_btn_n), .ring_n(ring_n), .rtc_alarm(rtc_alarm), .pme_evt(pme_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .next_state(next_state), .wake_req(wake_req),
        .status_flags(status_flags), .enable_bits(enable_bits)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            case (it.fld)
                F_STATE: act = int'(next_state);
                F_WAKE:  act = int'(wake_req);
                F_FLAGS: act = int'(status_flags);
                default: act = int'(enable_bits);
            endcase
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s field=%0d actual=%0h expected=%0h", it.req, it.fld, act, it.exp);
            end
        end
    end

    task automatic expect_v(string req, int fld, int exp);
        item_t it;
        it.req = req; it.fld = fld; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 6'(d);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic loss();
        stby_ok = 1'b0; main_pok = 1'b0;
        step(3);
    endtask

    task automatic back();
        stby_ok = 1'b1; main_pok = 1'b1;
        step(1);
    endtask

    task automatic finish_run();
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rtc_rst_n = 0; stby_ok = 0; main_pok = 0; pwr_btn_n = 1; ring_n = 1;
        rtc_alarm = 0; pme_evt = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        step(2);
        // R9 cold reset state
        expect_v("R9 cold state", F_STATE, 5);
        expect_v("R9 cold flags", F_FLAGS, 0);
        expect_v("R9 cold enables", F_EN, 0);
        rtc_rst_n = 1;
        step(1);
        expect_v("R8 both loss flags", F_FLAGS, 'h30);
        back();
        expect_v("R3 boot from S5 policy 0", F_STATE, 0);
        wr(2, 'h30);
        expect_v("R11 w1c", F_FLAGS, 0);

        // R11 set wins over clear
        main_pok = 0;
        wr(2, 'h20);
        expect_v("R11 set wins / R8 main only", F_FLAGS, 'h20);
        main_pok = 1;
        wr(2, 'h20);
        expect_v("R11 clear after", F_FLAGS, 0);

        // R12 sleep writes
        wr(0, 3);
        expect_v("R12 valid code", F_STATE, 3);
        wr(0, 2);
        expect_v("R12 invalid code 2", F_STATE, 3);
        wr(0, 7);
        expect_v("R12 invalid code 7", F_STATE, 3);

        // R5 / R4 button in S0 sets flag but no wake
        wr(0, 0);
        pwr_btn_n = 0;
        step(1);
        expect_v("R5 button flag", F_FLAGS, 1);
        step(1);
        expect_v("R4 no wake in S0", F_WAKE, 0);
        pwr_btn_n = 1;
        wr(2, 1);

        // R1 S3 with stay-off
        wr(1, 1);
        wr(0, 3);
        loss();
        back();
        expect_v("R1 S3 to S5", F_STATE, 5);
        expect_v("R8 flags after return", F_FLAGS, 'h30);
        expect_v("R4 no wake without event", F_WAKE, 0);
        wr(2, 'h30);
        pwr_btn_n = 0;
        step(1);
        expect_v("R5 button flag asleep", F_FLAGS, 1);
        expect_v("R4 wake not yet", F_WAKE, 0);
        step(1);
        expect_v("R4 button wake pulse", F_WAKE, 1);
        expect_v("R4 state on after wake", F_STATE, 0);
        step(1);
        expect_v("R4 single pulse", F_WAKE, 0);
        pwr_btn_n = 1;
        wr(2, 'h3F);

        wr(0, 1);
        loss(); back();
        expect_v("R1 S1 to S5", F_STATE, 5);
        wr(0, 0);
        loss(); back();
        expect_v("R1 S0 to S5", F_STATE, 5);
        loss(); back();
        expect_v("R1 S5 stays S5", F_STATE, 5);
        wr(0, 4);
        loss(); back();
        expect_v("R2 S4 kept", F_STATE, 4);

        wr(1, 0);
        loss(); back();
        expect_v("R3 S4 to S0", F_STATE, 0);
        wr(0, 1);
        loss(); back();
        expect_v("R3 S1 to S0", F_STATE, 0);
        wr(2, 'h3F);

        // R6 events masked while standby absent
        wr(1, 1);
        wr(0, 5);
        stby_ok = 0; main_pok = 0; pwr_btn_n = 0; rtc_alarm = 1;
        step(2);
        expect_v("R6 btn/alarm forced clear", F_FLAGS, 'h30);
        pwr_btn_n = 1; rtc_alarm = 0;
        step(1);
        back();
        expect_v("R6 nothing latched", F_FLAGS, 'h30);
        step(1);
        expect_v("R6 no wake after return", F_WAKE, 0);
        expect_v("R6 still asleep", F_STATE, 5);
        wr(2, 'h3F);

        // R7 ring held low across return, enabled
        wr(1, 'h05);
        stby_ok = 0; main_pok = 0; ring_n = 0;
        step(3);
        back();
        expect_v("R7 ring flag at return", F_FLAGS, 'h32);
        expect_v("R7 state recovered", F_STATE, 5);
        step(1);
        expect_v("R7 ring wake", F_WAKE, 1);
        expect_v("R7 on after ring wake", F_STATE, 0);
        ring_n = 1;
        wr(2, 'h3F);

        // R7 ring disabled
        wr(1, 'h01);
        wr(0, 5);
        ring_n = 0;
        step(1);
        expect_v("R7 ring flag disabled", F_FLAGS, 'h02);
        step(1);
        expect_v("R7 no wake disabled", F_WAKE, 0);
        expect_v("R7 stays asleep", F_STATE, 5);
        ring_n = 1;
        wr(2, 'h02);
        expect_v("R11 ring cleared", F_FLAGS, 0);

        // R9 enables kept, alarm wake
        wr(1, 'h03);
        loss();
        expect_v("R9 enables during loss", F_EN, 3);
        back();
        expect_v("R9 enables after return", F_EN, 3);
        expect_v("R1 asleep for alarm", F_STATE, 5);
        rtc_alarm = 1;
        step(1);
        rtc_alarm = 0;
        expect_v("R4 alarm flag", F_FLAGS, 'h34);
        step(1);
        expect_v("R4 alarm wake", F_WAKE, 1);
        expect_v("R4 alarm on", F_STATE, 0);
        wr(2, 'h3F);

        // R10 PME never wakes
        wr(1, 'h09);
        wr(0, 5);
        pme_evt = 1;
        step(1);
        pme_evt = 0;
        expect_v("R10 pme flag", F_FLAGS, 'h08);
        step(1);
        expect_v("R10 no pme wake", F_WAKE, 0);
        step(1);
        expect_v("R10 stays asleep", F_STATE, 5);
        loss();
        expect_v("R6 pme flag cleared on loss", F_FLAGS, 'h30);
        expect_v("R9 pme enable kept", F_EN, 'h09);
        back();
        step(1);
        expect_v("R10 no wake after return", F_WAKE, 0);
        expect_v("R10 asleep after return", F_STATE, 5);
        wr(2, 'h3F);

        // R8 main loss alone
        main_pok = 0;
        step(1);
        expect_v("R8 main only", F_FLAGS, 'h20);
        main_pok = 1;
        wr(2, 'h3F);

        // R12 write while standby low ignored
        stby_ok = 0; main_pok = 0;
        step(1);
        wr(0, 4);
        step(1);
        back();
        expect_v("R12 write in loss ignored", F_STATE, 5);

        // R9 cold reset clears enables
        rtc_rst_n = 0;
        step(1);
        expect_v("R9 cold clears enables", F_EN, 0);
        expect_v("R9 cold clears flags", F_FLAGS, 0);
        expect_v("R9 cold state S5", F_STATE, 5);
        rtc_rst_n = 1;
        step(1);
        expect_v("R3 boot after cold", F_STATE, 0);

        done = 1;
        finish_run();
    end
endmodule